// File: doc/BRIEF.md
# Multi-Thread Event Counter Unit

This block is a small performance-monitoring unit for a processor core that runs four hardware threads. It has two independent 24-bit event counters. Each thread drives a bank of single-cycle event pulses into the unit, one line for each event number. Each counter has a control word that selects one event number, a mask of the threads to watch and an interrupt enable. In every clock cycle a counter adds the number of selected threads that pulse the chosen event, from 0 to 4. The count is therefore a sum over the selected threads.

Event numbers at or above a configurable threshold are global. For these, every thread contributes and the mask is ignored. Event number 0 turns a counter off.

Software can load any 24-bit value into a counter. This lets it set a counter to roll over after a chosen number of events. When a counter rolls over past its maximum, a sticky status bit is set. An interrupt line is raised while any enabled status bit is set. Access goes through a simple valid/ready port on 8-byte register spacing, and read data comes back one cycle after the request.

Top module: `evcnt_unit`

## Requirements
- R1: After reset every counter, control word and status bit reads 0, and the interrupt output is low.
- R2: The counter adds, in each cycle, the number of threads whose mask bit is set and whose pulse line for the programmed event is high (0 to 4). Threads outside the mask add nothing, and the count holds when no selected thread pulses that event.
- R3: Event numbers 12 and above are global. Pulses from all four threads count, whatever the thread mask holds.
- R4: A counter whose event number is 0 holds its value, whatever pulses arrive.
- R5: The count wraps modulo 2^24. A step that carries past 0xFFFFFF sets that counter's sticky status bit.
- R6: Writing the status register clears each status bit written as 1. Bits written as 0 are unchanged. A rollover in the same cycle as a clear leaves the bit set.
- R7: The interrupt output goes high one cycle after a status bit whose counter has the interrupt enable set becomes 1. It goes low one cycle after no enabled bit remains set. A set status bit with its enable clear leaves the interrupt low.
- R8: A write to a count register loads bits [23:0] of the data. Bits above 23 are dropped and read as 0. Events in the same cycle as the write are discarded.
- R9: The address map is as follows. Count k is at byte 8·k, control k is at 0x10+8·k and status is at 0x20. The control word holds the event number in [3:0], the thread mask in [11:8] (bit 8 = thread 0) and the interrupt enable in [16]. Status bit k belongs to counter k. The ready output is always high, and rsp_valid and the read data appear one cycle after an accepted request.
- R10: The two counters are independent. Pulses that match only one counter's configuration leave the other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | 64 | Event pulses, thread t event e at bit t*16+e |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read/write response valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with its default parameters: two counters, four threads, sixteen event lines per thread, 24-bit counts and a global threshold of 12. With four threads, a single cycle can add 3 or 4, so a counter preset near 0xFFFFFF jumps past the top and lands on a small nonzero value. This tests the carry out rather than only the exact 0xFFFFFF to 0 step. The two-counter build lets the bench race a status clear against a rollover and check counter isolation through the shared port.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int unsigned CTL_MASK_LSB = 8;
  localparam int unsigned CTL_IE_BIT   = 16;
  localparam int unsigned WORD_SHIFT   = 3;
endpackage

// File: rtl/evcnt_inc.sv
module evcnt_inc #(
  parameter int NUM_THREADS  = 4,
  parameter int NUM_EVT      = 16,
  parameter int GLOBAL_FIRST = 12,
  localparam int EVT_W = $clog2(NUM_EVT),
  localparam int INC_W = $clog2(NUM_THREADS + 1)
) (
  input  logic [NUM_THREADS*NUM_EVT-1:0] evt_i,
  input  logic [EVT_W-1:0]               id_i,
  input  logic [NUM_THREADS-1:0]         mask_i,
  output logic [INC_W-1:0]               inc_o
);
  logic is_global;
  logic [NUM_THREADS-1:0] hit;

  assign is_global = (int'(id_i) >= GLOBAL_FIRST);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign hit[t] = (id_i != '0) && (is_global || mask_i[t]) &&
                    evt_i[t*NUM_EVT + int'(id_i)];
  end

  always_comb begin
    inc_o = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (hit[t]) inc_o = inc_o + INC_W'(1);
  end
endmodule

// File: rtl/evcnt_slot.sv
module evcnt_slot #(
  parameter int NUM_THREADS  = 4,
  parameter int NUM_EVT      = 16,
  parameter int GLOBAL_FIRST = 12,
  parameter int CNT_W        = 24,
  localparam int EVT_W = $clog2(NUM_EVT),
  localparam int INC_W = $clog2(NUM_THREADS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic [NUM_THREADS*NUM_EVT-1:0] evt_i,
  input  logic                           cnt_we_i,
  input  logic [CNT_W-1:0]               cnt_wdata_i,
  input  logic                           ctl_we_i,
  input  logic [EVT_W-1:0]               id_wdata_i,
  input  logic [NUM_THREADS-1:0]         mask_wdata_i,
  input  logic                           ie_wdata_i,
  input  logic                           sts_clr_i,
  output logic [CNT_W-1:0]               cnt_o,
  output logic [EVT_W-1:0]               id_o,
  output logic [NUM_THREADS-1:0]         mask_o,
  output logic                           ie_o,
  output logic                           sts_o
);
  logic [CNT_W-1:0]       cnt_q;
  logic [EVT_W-1:0]       id_q;
  logic [NUM_THREADS-1:0] mask_q;
  logic                   ie_q, sts_q;
  logic [INC_W-1:0]       inc;
  logic [CNT_W:0]         sum;
  logic                   wrap;

  evcnt_inc #(
    .NUM_THREADS(NUM_THREADS), .NUM_EVT(NUM_EVT), .GLOBAL_FIRST(GLOBAL_FIRST)
  ) u_inc (
    .evt_i(evt_i), .id_i(id_q), .mask_i(mask_q), .inc_o(inc)
  );

  assign sum  = {1'b0, cnt_q} + (CNT_W+1)'(inc);
  assign wrap = !cnt_we_i && sum[CNT_W];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      id_q   <= '0;
      mask_q <= '0;
      ie_q   <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (cnt_we_i)        cnt_q <= cnt_wdata_i;
      else if (id_q != '0) cnt_q <= sum[CNT_W-1:0];
      if (ctl_we_i) begin
        id_q   <= id_wdata_i;
        mask_q <= mask_wdata_i;
        ie_q   <= ie_wdata_i;
      end
      if (wrap)           sts_q <= 1'b1;
      else if (sts_clr_i) sts_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign id_o   = id_q;
  assign mask_o = mask_q;
  assign ie_o   = ie_q;
  assign sts_o  = sts_q;

  assert_step_bounded_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(inc) <= NUM_THREADS);
  assert_hold_disabled_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (id_q == '0 && !cnt_we_i) |=> cnt_q == $past(cnt_q));
  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_we_i |=> cnt_q == $past(cnt_wdata_i));
  assert_wrap_sets_status_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (id_q != '0 && !cnt_we_i && sum[CNT_W]) |=> sts_q);
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit #(
  parameter int NUM_CNT      = 2,
  parameter int NUM_THREADS  = 4,
  parameter int NUM_EVT      = 16,
  parameter int GLOBAL_FIRST = 12,
  parameter int CNT_W        = 24,
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 32,
  localparam int EVT_W  = $clog2(NUM_EVT),
  localparam int IDX_W  = ADDR_W - evcnt_pkg::WORD_SHIFT
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic [NUM_THREADS*NUM_EVT-1:0] evt_i,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic                           req_write_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [DATA_W-1:0]              req_wdata_i,
  output logic                           rsp_valid_o,
  output logic [DATA_W-1:0]              rsp_rdata_o,
  output logic                           irq_o
);
  import evcnt_pkg::*;

  logic [IDX_W-1:0] widx;
  logic             aligned, wr;
  logic [NUM_CNT-1:0] sts, ie;
  logic [NUM_CNT-1:0][CNT_W-1:0]       cnt;
  logic [NUM_CNT-1:0][EVT_W-1:0]       id;
  logic [NUM_CNT-1:0][NUM_THREADS-1:0] mask;
  logic [DATA_W-1:0] rd_mux;
  logic              rsp_valid_q, irq_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign widx    = req_addr_i[ADDR_W-1:WORD_SHIFT];
  assign aligned = (req_addr_i[WORD_SHIFT-1:0] == '0);
  assign wr      = req_valid_i && req_write_i && aligned;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
    evcnt_slot #(
      .NUM_THREADS(NUM_THREADS), .NUM_EVT(NUM_EVT),
      .GLOBAL_FIRST(GLOBAL_FIRST), .CNT_W(CNT_W)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .evt_i       (evt_i),
      .cnt_we_i    (wr && int'(widx) == k),
      .cnt_wdata_i (req_wdata_i[CNT_W-1:0]),
      .ctl_we_i    (wr && int'(widx) == NUM_CNT + k),
      .id_wdata_i  (req_wdata_i[EVT_W-1:0]),
      .mask_wdata_i(req_wdata_i[CTL_MASK_LSB +: NUM_THREADS]),
      .ie_wdata_i  (req_wdata_i[CTL_IE_BIT]),
      .sts_clr_i   (wr && int'(widx) == 2*NUM_CNT && req_wdata_i[k]),
      .cnt_o       (cnt[k]),
      .id_o        (id[k]),
      .mask_o      (mask[k]),
      .ie_o        (ie[k]),
      .sts_o       (sts[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if (int'(widx) == k) rd_mux[CNT_W-1:0] = cnt[k];
        if (int'(widx) == NUM_CNT + k) begin
          rd_mux[EVT_W-1:0] = id[k];
          rd_mux[CTL_MASK_LSB +: NUM_THREADS] = mask[k];
          rd_mux[CTL_IE_BIT] = ie[k];
        end
      end
      if (int'(widx) == 2*NUM_CNT) rd_mux[NUM_CNT-1:0] = sts;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      irq_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_rdata_q <= (req_valid_i && !req_write_i) ? rd_mux : '0;
      irq_q       <= |(sts & ie);
    end
  end

  assign req_ready_o = 1'b1;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign irq_o       = irq_q;

  assert_irq_follows_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ##1 irq_o == $past(|(sts & ie)));
  assert_rsp_latency_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    req_valid_i |=> rsp_valid_o);
endmodule

// File: tb/evcnt_unit_tb.sv
module evcnt_unit_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [63:0] evt = '0;
  logic req_valid = 0, req_write = 0, req_ready, rsp_valid, irq;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evcnt_unit u_dut (
    .clk_i(clk), .rst_i(rst), .evt_i(evt),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic expect_reg(string tag, logic [5:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  function automatic logic [63:0] pulses(int id, logic [3:0] thr);
    logic [63:0] v = '0;
    for (int t = 0; t < 4; t++) v[t*16 + id] = thr[t];
    return v;
  endfunction

  task automatic fire(int id, logic [3:0] thr);
    @(negedge clk);
    evt = pulses(id, thr);
    @(negedge clk);
    evt = '0;
  endtask

  task automatic fire_with_write(int id, logic [3:0] thr, logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    evt = pulses(id, thr);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    evt = '0; req_valid = 0; req_write = 0;
  endtask

  function automatic logic [31:0] ctl(int id, logic [3:0] m, bit ie);
    return 32'(id) | (32'(m) << 8) | (32'(ie) << 16);
  endfunction

  task automatic t_reset;
    check("R1 irq", {31'b0, irq}, 0);
    check("R9 ready", {31'b0, req_ready}, 1);
    expect_reg("R1 count0", 6'h00, 0);
    expect_reg("R1 count1", 6'h08, 0);
    expect_reg("R1 ctrl0", 6'h10, 0);
    expect_reg("R1 status", 6'h20, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(6'h18, ctl(9, 4'b0110, 1));
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 6'h18;
    @(negedge clk);
    req_valid = 0;
    check("R9 rsp_valid", {31'b0, rsp_valid}, 1);
    check("R9 ctrl1 readback", rsp_rdata, ctl(9, 4'b0110, 1));
    wr(6'h18, 0);
  endtask

  task automatic t_mask_sum;
    wr(6'h10, ctl(3, 4'b0001, 0));
    fire(3, 4'b0111);
    expect_reg("R2 single thread of three", 6'h00, 1);
    fire(3, 4'b0010);
    expect_reg("R2 unselected thread", 6'h00, 1);
    wr(6'h10, ctl(3, 4'b1011, 0));
    fire(3, 4'b1111);
    expect_reg("R2 three of four summed", 6'h00, 4);
    fire(5, 4'b1111);
    expect_reg("R2 other event ignored", 6'h00, 4);
  endtask

  task automatic t_global;
    wr(6'h10, ctl(13, 4'b0001, 0));
    fire(13, 4'b1111);
    expect_reg("R3 global counts all threads", 6'h00, 8);
  endtask

  task automatic t_disabled;
    wr(6'h10, ctl(0, 4'b1111, 0));
    fire(0, 4'b1111);
    expect_reg("R4 id0 holds", 6'h00, 8);
  endtask

  task automatic t_wrap_irq;
    wr(6'h00, 32'h00FF_FFFE);
    wr(6'h10, ctl(3, 4'b1111, 1));
    fire(3, 4'b0111);
    check("R7 irq one cycle late", {31'b0, irq}, 0);
    @(negedge clk);
    check("R7 irq raised", {31'b0, irq}, 1);
    expect_reg("R5 wrapped count", 6'h00, 1);
    expect_reg("R5 status set", 6'h20, 1);
    wr(6'h20, 32'h1);
    check("R7 irq still high", {31'b0, irq}, 1);
    @(negedge clk);
    check("R7 irq dropped", {31'b0, irq}, 0);
    expect_reg("R6 status cleared", 6'h20, 0);
    wr(6'h00, 32'h00FF_FFFF);
    fire(3, 4'b0001);
    expect_reg("R5 exact wrap to zero", 6'h00, 0);
    expect_reg("R5 status on exact wrap", 6'h20, 1);
    wr(6'h20, 32'h1);
  endtask

  task automatic t_write_priority;
    wr(6'h10, ctl(3, 4'b1111, 0));
    fire_with_write(3, 4'b1111, 6'h00, 32'h0000_0100);
    expect_reg("R8 write beats events", 6'h00, 32'h100);
    wr(6'h00, 32'hAB12_3456);
    expect_reg("R8 upper bits dropped", 6'h00, 32'h0012_3456);
  endtask

  task automatic t_set_wins;
    wr(6'h08, 32'h00FF_FFFF);
    wr(6'h18, ctl(13, 4'b0000, 0));
    fire_with_write(13, 4'b0100, 6'h20, 32'h2);
    expect_reg("R6 set beats clear", 6'h20, 2);
    expect_reg("R5 count1 wrapped", 6'h08, 0);
    check("R7 disabled bit no irq", {31'b0, irq}, 0);
    wr(6'h20, 32'h0);
    expect_reg("R6 zero write keeps", 6'h20, 2);
    wr(6'h20, 32'h2);
    expect_reg("R6 one clears", 6'h20, 0);
  endtask

  task automatic t_independent;
    wr(6'h00, 0); wr(6'h08, 0);
    wr(6'h10, ctl(3, 4'b0001, 0));
    wr(6'h18, ctl(5, 4'b0010, 0));
    fire(3, 4'b0011);
    expect_reg("R10 c0 counts", 6'h00, 1);
    expect_reg("R10 c1 untouched", 6'h08, 0);
    fire(5, 4'b0010);
    expect_reg("R10 c1 counts", 6'h08, 1);
    expect_reg("R10 c0 untouched", 6'h00, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_map();
    t_mask_sum();
    t_global();
    t_disabled();
    t_wrap_irq();
    t_write_priority();
    t_set_wins();
    t_independent();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule